// File: doc/BRIEF.md
# Masked Interrupt Priority Resolver

This block sits between a set of on-chip peripheral interrupt lines and a processor. Each peripheral line has a 4-bit priority. Software loads these priorities through a small write port. A separate debug-break input is caught on its rising edge and has a fixed top level of 15. On every idle cycle the block compares the pending sources against the processor's current 4-bit mask. It picks one winner and raises a registered request that carries the winner's vector number and the mask level the processor should adopt.

The processor acknowledges the request to accept it. While the request is pending, the vector and the new mask do not change. The only exception is a peripheral winner whose line falls: the request is then withdrawn and arbitration runs again. Each source has its own vector number, so the handler knows the cause without polling.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, `cpu_req` is 0, every priority field is 0 and no break is pending, so no request appears until software programs a priority.
- R2: Writing with `cfg_we` high stores `cfg_prio` as the priority of source `cfg_idx`. A write to an index at or above NUM_SRC is ignored. Priority 0 disables a source, because no mask value is below 0.
- R3: A source is eligible only when its request is active and its priority is strictly greater than `cur_mask`.
- R4: Among eligible peripheral sources, the highest priority wins. Among equal priorities, the lowest source index wins.
- R5: Peripheral source i is presented with vector VEC_BASE + i (default 64 + i). The break source is presented with vector BRK_VEC (default 11).
- R6: `cpu_new_mask` equals the priority of the presented peripheral source.
- R7: A rising edge on `brk_evt` is latched and held until its request is acknowledged. A level that stays high does not latch again. A mask of 15 blocks the break.
- R8: A pending break has level 15 and beats a peripheral source at level 15. Its `cpu_new_mask` is 15.
- R9: `cpu_req` is registered. It rises on the clock edge after the inputs qualify. While it is high and unacknowledged, `cpu_vec` and `cpu_new_mask` stay constant, even when a higher source arrives.
- R10: If the request line of the presented peripheral source goes low before acknowledge, `cpu_req` falls on the next edge.
- R11: On an edge where `cpu_req` and `cpu_ack` are both high, `cpu_req` falls. It stays low for at least one cycle before the next arbitration result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Level request per peripheral source |
| brk_evt | input | 1 | Debug-break event, rising-edge sensitive |
| cfg_we | input | 1 | Priority write strobe |
| cfg_idx | input | $clog2(NUM_SRC) | Source index for the write |
| cfg_prio | input | 4 | Priority value to store |
| cur_mask | input | 4 | Processor's current mask level |
| cpu_req | output | 1 | Registered interrupt request |
| cpu_ack | input | 1 | Acceptance from the processor |
| cpu_vec | output | VEC_W | Vector number of the presented source |
| cpu_new_mask | output | 4 | Mask level the processor takes on acceptance |

## Verification
The first sweep tests each source alone. It covers every priority against every mask value, which separates strict from non-strict comparison and shows that priority 0 is disabled. The second sweep enables all sources with priority patterns generated arithmetically from a stride and an offset. A stride of zero gives full ties, which shows the lowest-index rule; the other strides move the maximum between positions. Directed sequences cover the break: latching under a full mask, no second latch on a held level, and the tie with a level-15 peripheral. Other sequences check that a pending request is not replaced by a later higher source, and that a withdrawn level request is dropped.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PRIO_W = 4;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t MAX_PRIO = 4'hF;

    typedef struct packed {
        logic prev;
        logic pend;
    } brk_st_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 6,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int FLAT_W = NUM_SRC * PRIO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  prio_t            wr_val,
    output logic [FLAT_W-1:0] prio_flat
);
    logic [FLAT_W-1:0] flat_d, flat_q;

    always_comb begin
        flat_d = flat_q;
        if (wr_en && (int'(wr_idx) < NUM_SRC))
            flat_d[int'(wr_idx)*PRIO_W +: PRIO_W] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flat_q <= '0;
        else        flat_q <= flat_d;
    end

    assign prio_flat = flat_q;
endmodule

// File: rtl/irq_brk_latch.sv
module irq_brk_latch
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pend
);
    brk_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt;
        // a new edge in the clearing cycle is kept
        st_d.pend = (st_q.pend & ~clr) | (evt & ~st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 6,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int FLAT_W = NUM_SRC * PRIO_W
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [FLAT_W-1:0]  prio_flat,
    input  logic               brk_pend,
    input  prio_t              mask,
    output logic               any,
    output logic               win_brk,
    output logic [IDX_W-1:0]   win_idx,
    output prio_t              win_lvl
);
    always_comb begin
        prio_t best;
        best    = mask;
        any     = 1'b0;
        win_brk = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
                best    = prio_flat[i*PRIO_W +: PRIO_W];
                any     = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = best;
            end
        end
        if (brk_pend && (mask != MAX_PRIO)) begin
            any     = 1'b1;
            win_brk = 1'b1;
            win_idx = '0;
            win_lvl = MAX_PRIO;
        end
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = 6,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int BRK_VEC  = 11,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int FLAT_W  = NUM_SRC * PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               brk_evt,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [3:0]         cfg_prio,
    input  logic [3:0]         cur_mask,
    output logic               cpu_req,
    input  logic               cpu_ack,
    output logic [VEC_W-1:0]   cpu_vec,
    output logic [3:0]         cpu_new_mask
);
    typedef struct packed {
        logic             req;
        logic             brk;
        logic [IDX_W-1:0] idx;
        prio_t            lvl;
        logic [VEC_W-1:0] vec;
    } hs_t;

    hs_t hs_d, hs_q;

    logic [FLAT_W-1:0] prio_flat;
    logic              brk_pend;
    logic              brk_clr;
    logic              arb_any;
    logic              arb_brk;
    logic [IDX_W-1:0]  arb_idx;
    prio_t             arb_lvl;

    irq_prio_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_val   (cfg_prio),
        .prio_flat(prio_flat)
    );

    assign brk_clr = hs_q.req & cpu_ack & hs_q.brk;

    irq_brk_latch u_brk (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (brk_evt),
        .clr  (brk_clr),
        .pend (brk_pend)
    );

    irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .req      (src_req),
        .prio_flat(prio_flat),
        .brk_pend (brk_pend),
        .mask     (cur_mask),
        .any      (arb_any),
        .win_brk  (arb_brk),
        .win_idx  (arb_idx),
        .win_lvl  (arb_lvl)
    );

    always_comb begin
        hs_d = hs_q;
        if (hs_q.req) begin
            if (cpu_ack)
                hs_d.req = 1'b0;
            else if (!hs_q.brk && !src_req[hs_q.idx])
                hs_d.req = 1'b0;
        end else if (arb_any) begin
            hs_d.req = 1'b1;
            hs_d.brk = arb_brk;
            hs_d.idx = arb_idx;
            hs_d.lvl = arb_lvl;
            hs_d.vec = arb_brk ? VEC_W'(BRK_VEC)
                               : VEC_W'(VEC_BASE) + VEC_W'(arb_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign cpu_req      = hs_q.req;
    assign cpu_vec      = hs_q.vec;
    assign cpu_new_mask = hs_q.lvl;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
    parameter int NUM_SRC  = 6,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int BRK_VEC  = 11,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_req,
    input logic [3:0]         cur_mask,
    input logic               cpu_req,
    input logic               cpu_ack,
    input logic [VEC_W-1:0]   cpu_vec,
    input logic [3:0]         cpu_new_mask
);
    logic [VEC_W-1:0] rel;
    logic             is_brk;
    assign rel    = cpu_vec - VEC_W'(VEC_BASE);
    assign is_brk = (cpu_vec == VEC_W'(BRK_VEC));

    assert_above_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_req) |-> (cpu_new_mask > $past(cur_mask)));

    assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !is_brk) |-> (int'(rel) < NUM_SRC));

    assert_brk_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && is_brk) |-> (cpu_new_mask == 4'hF));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack) |=> (!cpu_req || ($stable(cpu_vec) && $stable(cpu_new_mask))));

    assert_level_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack && !is_brk && !src_req[rel[IDX_W-1:0]]) |=> !cpu_req);

    assert_ack_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> !cpu_req);
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE),
    .BRK_VEC (BRK_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req     (src_req),
    .cur_mask    (cur_mask),
    .cpu_req     (cpu_req),
    .cpu_ack     (cpu_ack),
    .cpu_vec     (cpu_vec),
    .cpu_new_mask(cpu_new_mask)
);

// File: tb/tb_irq_prio_resolver.sv
module tb_irq_prio_resolver;
    localparam int NS = 6;
    localparam int VB = 64;
    localparam int BV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic          brk_evt = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [3:0]    cfg_prio = '0;
    logic [3:0]    cur_mask = '0;
    logic          cpu_req;
    logic          cpu_ack = 1'b0;
    logic [7:0]    cpu_vec;
    logic [3:0]    cpu_new_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int pr [NS];

    irq_prio_resolver dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .brk_evt(brk_evt),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
        .cur_mask(cur_mask), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
        .cpu_vec(cpu_vec), .cpu_new_mask(cpu_new_mask)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_prio(input int i, input int p);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_prio = 4'(p);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic expect_req(input string tag, input int vec, input int lvl);
        chk(cpu_req === 1'b1, {tag, " req"}, int'(cpu_req), 1);
        chk(int'(cpu_vec) == vec, {tag, " vec"}, int'(cpu_vec), vec);
        chk(int'(cpu_new_mask) == lvl, {tag, " mask"}, int'(cpu_new_mask), lvl);
    endtask

    task automatic accept();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk(cpu_req === 1'b0, "R1 req in reset", int'(cpu_req), 0);
        rst_n = 1'b1;
        src_req = '1; cur_mask = 4'd0;
        tick(); tick();
        chk(cpu_req === 1'b0, "R1 prios zero after reset", int'(cpu_req), 0);
        src_req = '0; tick();

        // R2: out-of-range write ignored
        set_prio(6, 9); set_prio(7, 9);
        src_req = '1; tick(); tick();
        chk(cpu_req === 1'b0, "R2 out-of-range write", int'(cpu_req), 0);
        src_req = '0; tick();

        // R9: registered request, not combinational
        set_prio(2, 5); src_req = 6'b000100;
        #1 chk(cpu_req === 1'b0, "R9 registered latency", int'(cpu_req), 0);
        tick();
        expect_req("R9 first", VB + 2, 5);
        src_req = 6'b000101; set_prio(0, 9);
        repeat (3) begin
            tick();
            expect_req("R9 no rearbitration", VB + 2, 5);
        end
        cpu_ack = 1'b1; src_req = 6'b000001;
        tick(); cpu_ack = 1'b0;
        chk(cpu_req === 1'b0, "R11 gap after ack", int'(cpu_req), 0);
        tick();
        expect_req("R11 next winner", VB + 0, 9);
        src_req = '0; accept(); tick();

        // R10: presented level request withdrawn
        set_prio(1, 7); set_prio(4, 3);
        src_req = 6'b010010; tick();
        expect_req("R10 before drop", VB + 1, 7);
        src_req = 6'b010000; tick();
        chk(cpu_req === 1'b0, "R10 dropped", int'(cpu_req), 0);
        tick();
        expect_req("R10 rearbitrated", VB + 4, 3);
        src_req = '0; accept(); tick();

        // R7/R8: break latch
        cur_mask = 4'd15; brk_evt = 1'b1; tick(); brk_evt = 1'b0;
        repeat (4) tick();
        chk(cpu_req === 1'b0, "R7 blocked by mask 15", int'(cpu_req), 0);
        cur_mask = 4'd3; tick();
        expect_req("R7 held then presented", BV, 15);
        repeat (2) tick();
        expect_req("R9 break held", BV, 15);
        accept();
        chk(cpu_req === 1'b0, "R11 break ack", int'(cpu_req), 0);
        tick(); tick();
        chk(cpu_req === 1'b0, "R7 latch cleared", int'(cpu_req), 0);
        brk_evt = 1'b1; tick(); tick();
        expect_req("R7 edge latched", BV, 15);
        accept(); tick(); tick();
        chk(cpu_req === 1'b0, "R7 held level no relatch", int'(cpu_req), 0);
        brk_evt = 1'b0; tick();

        // R8: tie with level-15 peripheral
        set_prio(3, 15);
        cur_mask = 4'd15; brk_evt = 1'b1; src_req = 6'b001000;
        tick(); brk_evt = 1'b0; tick();
        cur_mask = 4'd0; tick();
        expect_req("R8 break beats 15", BV, 15);
        accept();
        tick();
        expect_req("R8 peripheral after break", VB + 3, 15);
        src_req = '0; accept(); tick();

        // R3/R5/R6/R2: single source sweep
        for (int i = 0; i < NS; i++) begin
            for (int p = 0; p < 16; p++) begin
                set_prio(i, p);
                for (int m = 0; m < 16; m++) begin
                    cur_mask = 4'(m);
                    src_req = 6'(1 << i);
                    tick();
                    if (p > m) begin
                        expect_req("R3 R5 R6 sweep", VB + i, p);
                        cpu_ack = 1'b1; src_req = '0;
                        tick(); cpu_ack = 1'b0;
                        chk(cpu_req === 1'b0, "R11 sweep ack", int'(cpu_req), 0);
                    end else begin
                        chk(cpu_req === 1'b0, "R3 R2 not above mask", int'(cpu_req), 0);
                        src_req = '0;
                    end
                    tick();
                end
            end
        end

        // R4: all sources, arithmetic priority patterns
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < 16; c++) begin
                int best, widx, m;
                src_req = '0;
                for (int i = 0; i < NS; i++) begin
                    pr[i] = (k * i + c) % 16;
                    set_prio(i, pr[i]);
                end
                m = (k + c) % 5;
                best = m; widx = -1;
                for (int i = 0; i < NS; i++)
                    if (pr[i] > best) begin best = pr[i]; widx = i; end
                cur_mask = 4'(m);
                src_req = '1;
                tick();
                if (widx >= 0) begin
                    expect_req("R4 pattern", VB + widx, best);
                    cpu_ack = 1'b1; src_req = '0;
                    tick(); cpu_ack = 1'b0;
                end else begin
                    chk(cpu_req === 1'b0, "R4 none eligible", int'(cpu_req), 0);
                    src_req = '0;
                end
                tick();
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule